// File: doc/BRIEF.md
# Multi-Mode DDS Phase Generator

This block is the digital front end of a direct digital synthesizer. A 48-bit phase accumulator adds a programmable frequency tuning word on every system clock. The top 14 bits of the accumulator are offset by a programmable phase adjustment and leave the block as an in-phase phase word. A quadrature phase word that is a quarter cycle ahead leaves alongside it, together with separate 12-bit amplitude words for the I and Q channels. Phase-to-amplitude conversion and the DAC sit downstream.

Software programs the block one byte at a time through a write port. Each write lands in a holding copy of its register. A single update strobe moves every holding register into the active set in one cycle, so the outputs never see a half-written multi-byte value. A 3-bit mode field is decoded and reported. Every mode drives the phase path in the single-tone way, from the one tuning word and the one phase offset. A synchronous master reset and the asynchronous reset both return the block to a silent state: 0 Hz, zero phase, zero amplitude and single-tone mode.

Top module: `dds_phase_gen`

## Requirements
- R1: While rst_ni is low, phase_i_o, amp_i_o, amp_q_o, mode_o and mode_bad_o are all 0 and phase_q_o is 4096.
- R2: A clock edge with mreset_i high clears the accumulator and both the holding and the active registers. After that edge phase_i_o, both amplitudes and mode_o are 0.
- R3: A byte write changes only the holding copy. No output changes until a later edge with update_i high.
- R4: On an edge with update_i high, every active register takes the holding value as it stood before that edge. Amplitudes and mode appear on the outputs right after that edge.
- R5: The accumulator adds the active tuning word on every edge, modulo 2^48. phase_i_o = accumulator[47:34] + phase offset, modulo 2^14.
- R6: The accumulator and the phase sum wrap without saturating. With tuning word 2^48-1 and offset 0x3FFF, three edges after the update give phase_i_o = 0x3FFE.
- R7: phase_q_o = phase_i_o + 4096 modulo 2^14 at all times.
- R8: mode_o reports the active mode code: 0 single tone, 1 FSK, 2 ramped FSK, 3 chirp, 4 BPSK. For these codes mode_bad_o is 0.
- R9: The active mode codes 5, 6 and 7 report mode_o = 0 and mode_bad_o = 1.
- R10: Byte map, with the lowest address of each field holding its most significant byte. Phase offset: 0x00 (bits 13:8) and 0x01. Tuning word: 0x04 (bits 47:40) through 0x09 (bits 7:0). I amplitude: 0x10 (bits 11:8) and 0x11. Q amplitude: 0x12 (bits 11:8) and 0x13. Mode: 0x1F, bits 2:0. A write to any other address changes no output.
- R11: Data bits above a field's width in its top byte are dropped: bits 7:6 at 0x00, bits 7:4 at 0x10 and 0x12, and bits 7:3 at 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreset_i | input | 1 | Synchronous master reset |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | 6 | Byte address |
| wr_data_i | input | 8 | Byte data |
| update_i | input | 1 | Copy holding registers to the active set |
| phase_i_o | output | 14 | In-phase phase word |
| phase_q_o | output | 14 | Quadrature phase word |
| amp_i_o | output | 12 | I amplitude |
| amp_q_o | output | 12 | Q amplitude |
| mode_o | output | 3 | Decoded mode code |
| mode_bad_o | output | 1 | Reserved mode code is active |

## Verification
Amplitude, mode and phase offset are due directly after the update edge. The phase offset reaches phase_i_o combinationally from the active register. The accumulator first uses a new tuning word on the edge after the update, because the update edge itself still adds the old word. The bench keeps a byte-level model that mirrors this ordering on every edge: accumulate with the old word, then load the active registers from the old holding bytes, then apply the write. It samples the outputs only at falling edges, half a cycle after the edge that changed them.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [2:0] {
    MODE_TONE  = 3'd0,
    MODE_FSK   = 3'd1,
    MODE_RFSK  = 3'd2,
    MODE_CHIRP = 3'd3,
    MODE_BPSK  = 3'd4
  } dds_mode_e;

  // base = most significant byte of each field
  localparam int unsigned ADDR_POFF  = 'h00;
  localparam int unsigned ADDR_FTW   = 'h04;
  localparam int unsigned ADDR_AMP   = 'h10;
  localparam int unsigned ADDR_MODE  = 'h1F;
endpackage

// File: rtl/dds_field.sv
module dds_field #(
  parameter int unsigned W      = 8,
  parameter int unsigned BASE   = 0,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreset_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              update_i,
  output logic [W-1:0]      val_o
);
  localparam int unsigned NB = (W + 7) / 8;
  localparam int unsigned PW = NB * 8;

  logic [W-1:0]  hold_q;
  logic [W-1:0]  act_q;
  logic [PW-1:0] wide_q;
  logic [PW-1:0] wide_d;

  assign wide_q = PW'(hold_q);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam int unsigned LO = (NB - 1 - b) * 8;
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(BASE + b));
    assign wide_d[LO +: 8] = hit ? wr_data_i : wide_q[LO +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
    end else if (mreset_i) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (update_i) act_q <= hold_q;  // old holding value
      hold_q <= W'(wide_d);            // drops bits above W
    end
  end

  assign val_o = act_q;
endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned PH_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreset_i,
  input  logic [ACC_W-1:0] ftw_i,
  output logic [PH_W-1:0]  top_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (mreset_i) acc_q <= '0;
    else               acc_q <= acc_q + ftw_i;
  end

  assign top_o = acc_q[ACC_W-1 -: PH_W];
endmodule

// File: rtl/dds_phase_out.sv
module dds_phase_out #(
  parameter int unsigned PH_W = 14
) (
  input  logic [PH_W-1:0] top_i,
  input  logic [PH_W-1:0] poff_i,
  output logic [PH_W-1:0] ph_i_o,
  output logic [PH_W-1:0] ph_q_o
);
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W - 2);

  logic [PH_W-1:0] poff_q;

  assign poff_q = poff_i + QTR;
  assign ph_i_o = top_i + poff_i;
  assign ph_q_o = top_i + poff_q;
endmodule

// File: rtl/dds_mode_dec.sv
module dds_mode_dec
  import dds_pkg::*;
(
  input  logic [2:0] raw_i,
  output logic [2:0] mode_o,
  output logic       bad_o
);
  dds_mode_e mode;

  always_comb begin
    bad_o = 1'b0;
    mode  = MODE_TONE;
    case (raw_i)
      3'd0: mode = MODE_TONE;
      3'd1: mode = MODE_FSK;
      3'd2: mode = MODE_RFSK;
      3'd3: mode = MODE_CHIRP;
      3'd4: mode = MODE_BPSK;
      default: begin
        mode  = MODE_TONE;  // reserved codes fall back to single tone
        bad_o = 1'b1;
      end
    endcase
  end

  assign mode_o = mode;
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned PH_W   = 14,
  parameter int unsigned AMP_W  = 12,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreset_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              update_i,
  output logic [PH_W-1:0]   phase_i_o,
  output logic [PH_W-1:0]   phase_q_o,
  output logic [AMP_W-1:0]  amp_i_o,
  output logic [AMP_W-1:0]  amp_q_o,
  output logic [2:0]        mode_o,
  output logic              mode_bad_o
);
  localparam int unsigned AMP_NB = (AMP_W + 7) / 8;
  localparam int unsigned N_CH   = 2;

  logic [ACC_W-1:0]            ftw;
  logic [PH_W-1:0]             poff;
  logic [PH_W-1:0]             acc_top;
  logic [2:0]                  mode_raw;
  logic [N_CH-1:0][AMP_W-1:0]  amp;

  dds_field #(.W(ACC_W), .BASE(ADDR_FTW), .ADDR_W(ADDR_W)) u_ftw (
    .clk_i, .rst_ni, .mreset_i, .wr_en_i, .wr_addr_i, .wr_data_i, .update_i,
    .val_o(ftw)
  );

  dds_field #(.W(PH_W), .BASE(ADDR_POFF), .ADDR_W(ADDR_W)) u_poff (
    .clk_i, .rst_ni, .mreset_i, .wr_en_i, .wr_addr_i, .wr_data_i, .update_i,
    .val_o(poff)
  );

  dds_field #(.W(3), .BASE(ADDR_MODE), .ADDR_W(ADDR_W)) u_mode (
    .clk_i, .rst_ni, .mreset_i, .wr_en_i, .wr_addr_i, .wr_data_i, .update_i,
    .val_o(mode_raw)
  );

  // channel 0 = I, channel 1 = Q, packed back to back
  for (genvar c = 0; c < N_CH; c++) begin : g_amp
    dds_field #(.W(AMP_W), .BASE(ADDR_AMP + c * AMP_NB), .ADDR_W(ADDR_W)) u_amp (
      .clk_i, .rst_ni, .mreset_i, .wr_en_i, .wr_addr_i, .wr_data_i, .update_i,
      .val_o(amp[c])
    );
  end

  dds_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk_i, .rst_ni, .mreset_i,
    .ftw_i (ftw),
    .top_o (acc_top)
  );

  dds_phase_out #(.PH_W(PH_W)) u_out (
    .top_i  (acc_top),
    .poff_i (poff),
    .ph_i_o (phase_i_o),
    .ph_q_o (phase_q_o)
  );

  dds_mode_dec u_dec (
    .raw_i  (mode_raw),
    .mode_o (mode_o),
    .bad_o  (mode_bad_o)
  );

  assign amp_i_o = amp[0];
  assign amp_q_o = amp[1];
endmodule

// File: rtl/dds_phase_gen_chk.sv
module dds_phase_gen_chk #(
  parameter int unsigned PH_W  = 14,
  parameter int unsigned AMP_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mreset_i,
  input logic             update_i,
  input logic [PH_W-1:0]  phase_i_o,
  input logic [PH_W-1:0]  phase_q_o,
  input logic [AMP_W-1:0] amp_i_o,
  input logic [AMP_W-1:0] amp_q_o,
  input logic [2:0]       mode_o,
  input logic             mode_bad_o
);
  localparam logic [PH_W-1:0] QTR = PH_W'(1) << (PH_W - 2);

  a_r2_mreset_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset_i |=> (phase_i_o == '0) && (amp_i_o == '0) && (amp_q_o == '0)
                 && (mode_o == 3'd0) && !mode_bad_o);

  a_r3_hold_until_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && !mreset_i) |=> $stable(amp_i_o) && $stable(amp_q_o)
                                 && $stable(mode_o) && $stable(mode_bad_o));

  a_r7_quadrature: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q_o == phase_i_o + QTR);

  a_r8_mode_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);

  a_r9_reserved_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_bad_o |-> (mode_o == 3'd0));
endmodule

bind dds_phase_gen dds_phase_gen_chk #(.PH_W(PH_W), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/dds_phase_gen_tb.sv
module dds_phase_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5eed_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrst = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd = 1'b0;
  logic [13:0] ph_i, ph_q;
  logic [11:0] a_i, a_q;
  logic [2:0]  mode;
  logic        bad;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model
  logic [7:0]  mb [64];
  logic [47:0] m_acc, m_ftw;
  logic [13:0] m_poff;
  logic [11:0] m_ai, m_aq;
  logic [2:0]  m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_phase_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mreset_i(mrst), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .update_i(upd),
    .phase_i_o(ph_i), .phase_q_o(ph_q), .amp_i_o(a_i), .amp_q_o(a_q),
    .mode_o(mode), .mode_bad_o(bad)
  );

  function automatic logic [13:0] exp_i();
    return m_acc[47:34] + m_poff;
  endfunction

  function automatic logic [2:0] exp_mode();
    return (m_mode > 3'd4) ? 3'd0 : m_mode;
  endfunction

  task automatic clear_model();
    for (int k = 0; k < 64; k++) mb[k] = '0;
    m_acc = '0; m_ftw = '0; m_poff = '0; m_ai = '0; m_aq = '0; m_mode = '0;
  endtask

  task automatic load_active();
    m_ftw  = {mb[4], mb[5], mb[6], mb[7], mb[8], mb[9]};
    m_poff = {mb[0][5:0], mb[1]};
    m_ai   = {mb[16][3:0], mb[17]};
    m_aq   = {mb[18][3:0], mb[19]};
    m_mode = mb[31][2:0];
  endtask

  // one rising edge with the currently driven inputs
  task automatic step();
    if (mrst) clear_model();
    else begin
      m_acc = m_acc + m_ftw;
      if (upd) load_active();
      if (wr_en) mb[wr_addr] = wr_data;
    end
    @(negedge clk);
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " phase_i (R5)"}, ph_i, exp_i());
    chk({tag, " phase_q (R7)"}, ph_q, 14'(exp_i() + 14'd4096));
    chk({tag, " amp_i (R4)"}, a_i, m_ai);
    chk({tag, " amp_q (R4)"}, a_q, m_aq);
    chk({tag, " mode (R8)"}, mode, exp_mode());
    chk({tag, " bad (R9)"}, bad, m_mode > 3'd4);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic update();
    upd = 1'b1; step(); upd = 1'b0;
  endtask

  task automatic mreset();
    mrst = 1'b1; step(); mrst = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(SEED);
    clear_model();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 phase_i", ph_i, 0);
    chk("R1 phase_q", ph_q, 14'd4096);
    chk("R1 amp_i", a_i, 0);
    chk("R1 amp_q", a_q, 0);
    chk("R1 mode", mode, 0);
    chk("R1 bad", bad, 0);
    rst_n = 1'b1;
    step(); chk_all("R1 after release");

    // R3 writes without update
    wr(6'h04, 8'h01); wr(6'h09, 8'h55); wr(6'h01, 8'h20);
    wr(6'h10, 8'h0A); wr(6'h11, 8'hBC); wr(6'h13, 8'h77); wr(6'h1F, 8'h03);
    repeat (3) step();
    chk("R3 amp_i held", a_i, 0);
    chk("R3 mode held", mode, 0);
    chk_all("R3");

    // R4 update, then R5 accumulate
    update();
    chk("R4 amp_i", a_i, 12'hABC);
    chk("R4 amp_q", a_q, 12'h077);
    chk("R4 mode chirp R8", mode, 3);
    for (int k = 0; k < 10; k++) begin
      step(); chk_all("R5 run");
    end

    // R10 unmapped writes
    wr(6'h02, 8'hFF); wr(6'h0C, 8'hFF); wr(6'h3F, 8'hFF); wr(6'h14, 8'hFF);
    update();
    chk("R10 amp_i unchanged", a_i, 12'hABC);
    chk("R10 amp_q unchanged", a_q, 12'h077);
    chk_all("R10");

    // R2 master reset mid-run
    mreset();
    chk("R2 phase_i", ph_i, 0);
    chk("R2 amp_i", a_i, 0);
    chk("R2 mode", mode, 0);
    step(); chk_all("R2 after");

    // R6 wrap
    for (int k = 4; k <= 9; k++) wr(6'(k), 8'hFF);
    wr(6'h00, 8'h3F); wr(6'h01, 8'hFF);
    update();
    repeat (3) step();
    chk("R6 wrap phase_i", ph_i, 14'h3FFE);
    chk_all("R6");

    // R11 dropped upper bits
    wr(6'h00, 8'hFF); wr(6'h10, 8'hFF); wr(6'h12, 8'hF5);
    update();
    chk("R11 amp_i", a_i, 12'hF00 | 12'(m_ai[7:0]));
    chk("R11 amp_q", a_q, {4'h5, m_aq[7:0]});
    chk_all("R11");

    // R8 / R9 all mode codes, junk in upper bits (R11)
    for (int m = 0; m < 8; m++) begin
      wr(6'h1F, {5'b10101, 3'(m)});
      update();
      if (m > 4) begin
        chk("R9 mode", mode, 0);
        chk("R9 bad", bad, 1);
      end else begin
        chk("R8 mode", mode, m);
        chk("R8 bad", bad, 0);
      end
    end

    // random mix
    mreset();
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 55) begin
        wr_en = 1'b1; wr_addr = 6'($urandom_range(0, 63)); wr_data = 8'($urandom);
        step(); wr_en = 1'b0;
      end else if (op < 70) update();
      else if (op < 72) mreset();
      else step();
      chk_all("rand");
    end

    done = 1;
    summary();
  end
endmodule